// File: doc/BRIEF.md
# Dual-Tap Line Delay Memory

This block delays a stream of pixels by one line and by two lines at once. Pixels enter on a write port that runs on its own clock. They leave on a read port that runs on an independent clock. The block holds two line stores. The first store is filled from the write port. On every enabled read, the word taken from the first store is presented on the one-line tap. In the same read cycle that word is copied into the second store, so the second store always trails the first by exactly one read pass. Both taps are therefore driven from one read address sequence.

Four active-low controls steer the address counters. Two work on the write side: enable and reset. Two work on the read side: enable and reset. Pulsing the write reset and the read reset every N words, with N of at least 3, turns the block into an N-word delay instead of a full-line delay. The counters wrap at the end of a line and have no full or empty flags. The user has to keep the read side behind the write side.

Top module: `line_delay2x`

## Requirements
- R1: While `wr_en_n` is low and `wr_rst_n` is high, each rising `wr_clk` edge stores `wr_pix` at the current write address and advances that address. Read back in order, the one-line tap returns the words in the order they were written.
- R2: While `wr_en_n` is high, no word is stored and the write address holds. The stream read back has no gap and no extra word.
- R3: A low `wr_rst_n` on a `wr_clk` edge sets the write address to 0 and stores nothing, even if `wr_en_n` is low in the same cycle.
- R4: A `rd_clk` edge with `rd_en_n` low and `rd_rst_n` high loads the word at the read address onto `rd_pix1` and sets `rd_valid` high after that edge. All three read-side counters advance together.
- R5: On each enabled read, `rd_pix2` carries the value that `rd_pix1` carried one read pass earlier. A pass is LINE_WORDS reads, or the read-reset period when resets are applied periodically.
- R6: A `rd_clk` edge with `rd_en_n` high and `rd_rst_n` high sets `rd_valid` low and holds every read-side counter. Both taps read as 0 while `rd_valid` is low, and the next enabled read continues with the next word.
- R7: A low `rd_rst_n` on a `rd_clk` edge sets three counters to 0: the first store's read address, and the second store's write and read addresses. It also sets `rd_valid` low. It takes priority over a low `rd_en_n`.
- R8: All counters wrap from LINE_WORDS-1 to 0. A stream longer than one line, written and read without any reset after the first, is returned intact across the wrap.
- R9: Applying `wr_rst_n` every N writes and `rd_rst_n` every N reads, with 3 <= N < LINE_WORDS, gives an N-word delay on the one-line tap and an N-read delay from `rd_pix1` to `rd_pix2`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_rst_n | input | 1 | Write address reset, active low, synchronous |
| wr_pix | input | PIX_W | Pixel to store |
| rd_clk | input | 1 | Read-side clock, independent of wr_clk |
| rd_en_n | input | 1 | Read enable, active low |
| rd_rst_n | input | 1 | Read-side address reset, active low, synchronous |
| rd_pix1 | output | PIX_W | One-line delayed pixel, 0 when not valid |
| rd_pix2 | output | PIX_W | Two-line delayed pixel, 0 when not valid |
| rd_valid | output | 1 | Taps carry data read on the last rd_clk edge |

## Verification
Two collisions matter most. The first is a read reset that lands in the same read cycle as a read enable. The bench holds `rd_en_n` low through every read-reset cycle. It then expects `rd_valid` low, and it expects the following read to return the first word of the line, not the second. The second collision is a write reset issued together with a write enable: the pixel presented in that cycle must not appear in the read stream. Every enabled read also reads and rewrites the same address of the second store on one edge. This is judged by comparing `rd_pix2` with the one-line value recorded one pass earlier.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

    // Operation chosen for the read side in one rd_clk cycle.
    typedef enum logic [1:0] {
        RD_HOLD  = 2'd0,
        RD_CLEAR = 2'd1,
        RD_STEP  = 2'd2
    } rd_op_e;

    // Address width needed to index a store of n words.
    function automatic int addr_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ldm_wrap_counter.sv
module ldm_wrap_counter #(
    parameter int DEPTH = 5120,
    parameter int AW    = ldm_pkg::addr_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          step,
    output logic [AW-1:0] count
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/ldm_line_store.sv
module ldm_line_store #(
    parameter int DEPTH = 5120,
    parameter int DW    = 8,
    parameter int AW    = ldm_pkg::addr_bits(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Asynchronous lookup; the owner registers it on its own clock.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/line_delay2x.sv
module line_delay2x
    import ldm_pkg::*;
#(
    parameter int LINE_WORDS = 5120,
    parameter int PIX_W      = 8
) (
    input  logic             wr_clk,
    input  logic             wr_en_n,
    input  logic             wr_rst_n,
    input  logic [PIX_W-1:0] wr_pix,
    input  logic             rd_clk,
    input  logic             rd_en_n,
    input  logic             rd_rst_n,
    output logic [PIX_W-1:0] rd_pix1,
    output logic [PIX_W-1:0] rd_pix2,
    output logic             rd_valid
);
    localparam int AW = addr_bits(LINE_WORDS);

    // ---------------- write side ----------------
    logic          wr_clr, wr_step;
    logic [AW-1:0] wr_addr_w;

    always_comb begin
        wr_clr  = ~wr_rst_n;
        wr_step = wr_rst_n & ~wr_en_n;
    end

    ldm_wrap_counter #(.DEPTH(LINE_WORDS), .AW(AW)) u_wr_cnt (
        .clk   (wr_clk),
        .clr   (wr_clr),
        .step  (wr_step),
        .count (wr_addr_w)
    );

    // ---------------- read side ----------------
    rd_op_e        rd_op;
    logic          rd_clr, rd_step;
    logic [AW-1:0] rd_addr1_w, wr_addr2_w, rd_addr2_w;
    logic [PIX_W-1:0] tap1_w, tap2_w;

    always_comb begin
        if (!rd_rst_n)      rd_op = RD_CLEAR;
        else if (!rd_en_n)  rd_op = RD_STEP;
        else                rd_op = RD_HOLD;
        rd_clr  = (rd_op == RD_CLEAR);
        rd_step = (rd_op == RD_STEP);
    end

    ldm_wrap_counter #(.DEPTH(LINE_WORDS), .AW(AW)) u_rd1_cnt (
        .clk   (rd_clk),
        .clr   (rd_clr),
        .step  (rd_step),
        .count (rd_addr1_w)
    );

    ldm_wrap_counter #(.DEPTH(LINE_WORDS), .AW(AW)) u_wr2_cnt (
        .clk   (rd_clk),
        .clr   (rd_clr),
        .step  (rd_step),
        .count (wr_addr2_w)
    );

    ldm_wrap_counter #(.DEPTH(LINE_WORDS), .AW(AW)) u_rd2_cnt (
        .clk   (rd_clk),
        .clr   (rd_clr),
        .step  (rd_step),
        .count (rd_addr2_w)
    );

    // First store: filled from the write port, drained on the read clock.
    ldm_line_store #(.DEPTH(LINE_WORDS), .DW(PIX_W), .AW(AW)) u_store1 (
        .wr_clk  (wr_clk),
        .wr_en   (wr_step),
        .wr_addr (wr_addr_w),
        .wr_data (wr_pix),
        .rd_addr (rd_addr1_w),
        .rd_data (tap1_w)
    );

    // Second store: refilled on the read clock with the one-line word.
    ldm_line_store #(.DEPTH(LINE_WORDS), .DW(PIX_W), .AW(AW)) u_store2 (
        .wr_clk  (rd_clk),
        .wr_en   (rd_step),
        .wr_addr (wr_addr2_w),
        .wr_data (tap1_w),
        .rd_addr (rd_addr2_w),
        .rd_data (tap2_w)
    );

    // Output register, two-process.
    typedef struct packed {
        logic [PIX_W-1:0] pix1;
        logic [PIX_W-1:0] pix2;
        logic             valid;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        case (rd_op)
            RD_STEP: begin
                out_d.pix1  = tap1_w;
                out_d.pix2  = tap2_w;
                out_d.valid = 1'b1;
            end
            default: begin
                out_d.valid = 1'b0;
            end
        endcase
    end

    always_ff @(posedge rd_clk) begin
        out_q <= out_d;
    end

    assign rd_valid = out_q.valid;
    assign rd_pix1  = out_q.valid ? out_q.pix1 : '0;
    assign rd_pix2  = out_q.valid ? out_q.pix2 : '0;
endmodule

// File: rtl/line_delay2x_chk.sv
module line_delay2x_chk #(
    parameter int LINE_WORDS = 5120,
    parameter int PIX_W      = 8
) (
    input logic                              wr_clk,
    input logic                              wr_en_n,
    input logic                              wr_rst_n,
    input logic [ldm_pkg::addr_bits(LINE_WORDS)-1:0] wr_addr,
    input logic                              rd_clk,
    input logic                              rd_en_n,
    input logic                              rd_rst_n,
    input logic [ldm_pkg::addr_bits(LINE_WORDS)-1:0] raddr1,
    input logic [ldm_pkg::addr_bits(LINE_WORDS)-1:0] waddr2,
    input logic [ldm_pkg::addr_bits(LINE_WORDS)-1:0] raddr2,
    input logic [PIX_W-1:0]                  rd_pix1,
    input logic [PIX_W-1:0]                  rd_pix2,
    input logic                              rd_valid
);
    localparam int AW = ldm_pkg::addr_bits(LINE_WORDS);
    localparam logic [AW-1:0] LAST = AW'(LINE_WORDS - 1);

    // Each side is checked only once its own reset has been seen.
    logic wr_armed = 1'b0;
    logic rd_armed = 1'b0;

    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) wr_armed <= 1'b1;
    end

    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) rd_armed <= 1'b1;
    end

    assert_wr_clear_R3: assert property (@(posedge wr_clk) disable iff (!wr_armed)
        !wr_rst_n |=> (wr_addr == '0));

    assert_wr_hold_R2: assert property (@(posedge wr_clk) disable iff (!wr_armed)
        (wr_rst_n && wr_en_n) |=> $stable(wr_addr));

    assert_wr_wrap_R8: assert property (@(posedge wr_clk) disable iff (!wr_armed)
        (wr_rst_n && !wr_en_n && wr_addr == LAST) |=> (wr_addr == '0));

    assert_rd_clear_R7: assert property (@(posedge rd_clk) disable iff (!rd_armed)
        !rd_rst_n |=> (raddr1 == '0 && waddr2 == '0 && raddr2 == '0 && !rd_valid));

    assert_rd_hold_R6: assert property (@(posedge rd_clk) disable iff (!rd_armed)
        (rd_rst_n && rd_en_n) |=> ($stable(raddr1) && $stable(raddr2) && !rd_valid
                                   && rd_pix1 == '0 && rd_pix2 == '0));

    assert_rd_step_R4: assert property (@(posedge rd_clk) disable iff (!rd_armed)
        (rd_rst_n && !rd_en_n) |=> rd_valid);

    assert_rd_lockstep_R5: assert property (@(posedge rd_clk) disable iff (!rd_armed)
        (raddr1 == raddr2) && (waddr2 == raddr2));

    assert_rd_wrap_R8: assert property (@(posedge rd_clk) disable iff (!rd_armed)
        (rd_rst_n && !rd_en_n && raddr1 == LAST) |=> (raddr1 == '0));
endmodule

bind line_delay2x line_delay2x_chk #(
    .LINE_WORDS (LINE_WORDS),
    .PIX_W      (PIX_W)
) u_chk (
    .wr_clk   (wr_clk),
    .wr_en_n  (wr_en_n),
    .wr_rst_n (wr_rst_n),
    .wr_addr  (wr_addr_w),
    .rd_clk   (rd_clk),
    .rd_en_n  (rd_en_n),
    .rd_rst_n (rd_rst_n),
    .raddr1   (rd_addr1_w),
    .waddr2   (wr_addr2_w),
    .raddr2   (rd_addr2_w),
    .rd_pix1  (rd_pix1),
    .rd_pix2  (rd_pix2),
    .rd_valid (rd_valid)
);

// File: tb/tb_line_delay2x.sv
`timescale 1ns/1ps
module tb_line_delay2x;
    localparam int LW = 5120;

    logic       wr_clk = 1'b0, rd_clk = 1'b0;
    logic       wr_en_n = 1'b1, wr_rst_n = 1'b1, rd_en_n = 1'b1, rd_rst_n = 1'b1;
    logic [7:0] wr_pix = 8'h00;
    logic [7:0] rd_pix1, rd_pix2;
    logic       rd_valid;

    line_delay2x dut (
        .wr_clk   (wr_clk),
        .wr_en_n  (wr_en_n),
        .wr_rst_n (wr_rst_n),
        .wr_pix   (wr_pix),
        .rd_clk   (rd_clk),
        .rd_en_n  (rd_en_n),
        .rd_rst_n (rd_rst_n),
        .rd_pix1  (rd_pix1),
        .rd_pix2  (rd_pix2),
        .rd_valid (rd_valid)
    );

    always #10   wr_clk = ~wr_clk;   // 50 MHz write clock
    always #6.5  rd_clk = ~rd_clk;   // unrelated read clock

    typedef struct {
        logic [7:0] data;
        bit         first;      // read reset due before this word
        bit         new_phase;  // two-line history restarts
        int         period;     // read pass length
        string      tag;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] hist[$];
    int  n_checks = 0, n_fail = 0;
    bit  writer_done = 0, finished = 0;
    int  wseq = 0;
    logic [7:0] lfsr = 8'h5A;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] next_pix();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        return lfsr ^ 8'(wseq);
    endfunction

    // Driver: writes lines and pushes expected words into the scoreboard.
    task automatic write_phase(input int words, input bit reset_each, input int lines,
                               input int period, input string tag);
        bit mark = 0;
        bit phase0 = 1;
        for (int ln = 0; ln < lines; ln++) begin
            if (ln == 0 || reset_each) begin
                // R3: reset together with enable; this pixel must never appear
                @(negedge wr_clk);
                wr_rst_n = 0; wr_en_n = 0; wr_pix = 8'hEE;
                @(posedge wr_clk); #1;
                mark = 1;
            end
            for (int k = 0; k < words; k++) begin
                if (wseq % 5 == 4) begin
                    // R2: disabled write cycle with a decoy pixel
                    @(negedge wr_clk);
                    wr_rst_n = 1; wr_en_n = 1; wr_pix = 8'hC3;
                    @(posedge wr_clk); #1;
                end
                @(negedge wr_clk);
                wr_rst_n = 1; wr_en_n = 0; wr_pix = next_pix();
                @(posedge wr_clk); #1;
                begin
                    item_t it;
                    it.data = wr_pix; it.first = mark; it.new_phase = mark && phase0;
                    it.period = period;
                    it.tag = (period == LW && k >= LW) ? "R8" : tag;
                    exp_q.push_back(it);
                end
                mark = 0; phase0 = 0; wseq++;
            end
        end
        @(negedge wr_clk);
        wr_en_n = 1;
    endtask

    // Monitor: drives reads, pops the scoreboard and compares both taps.
    task automatic reader();
        int  dec = 0;
        bit  rst_done = 0;
        forever begin
            @(negedge rd_clk);
            if (writer_done && exp_q.size() == 0) break;
            dec++;
            if (exp_q.size() == 0 || dec % 7 == 0) begin
                rd_rst_n = 1; rd_en_n = 1;
                @(posedge rd_clk); #2;
                check(rd_valid == 1'b0, "R6 valid", int'(rd_valid), 0);
                check(rd_pix1 == 8'h00 && rd_pix2 == 8'h00, "R6 taps",
                      int'({rd_pix1, rd_pix2}), 0);
            end else if (exp_q[0].first && !rst_done) begin
                // R7: read reset with read enable low in the same cycle
                rd_rst_n = 0; rd_en_n = 0;
                @(posedge rd_clk); #2;
                check(rd_valid == 1'b0, "R7 valid", int'(rd_valid), 0);
                rst_done = 1;
                if (exp_q[0].new_phase) hist.delete();
            end else begin
                item_t it = exp_q.pop_front();
                rd_rst_n = 1; rd_en_n = 0;
                @(posedge rd_clk); #2;
                check(rd_valid == 1'b1, "R4 valid", int'(rd_valid), 1);
                check(rd_pix1 == it.data, {it.tag, " tap1"}, int'(rd_pix1), int'(it.data));
                if (hist.size() >= it.period) begin
                    logic [7:0] e2 = hist[hist.size() - it.period];
                    check(rd_pix2 == e2, "R5 tap2", int'(rd_pix2), int'(e2));
                end
                hist.push_back(it.data);
                rst_done = 0;
            end
        end
        @(negedge rd_clk);
        rd_en_n = 1;
    endtask

    initial begin
        // Reset state: both resets applied, taps not valid afterwards (R7).
        @(negedge wr_clk); wr_rst_n = 0;
        @(posedge wr_clk); #1; wr_rst_n = 1;
        @(negedge rd_clk); rd_rst_n = 0;
        @(posedge rd_clk); #2;
        check(rd_valid == 1'b0, "R7 reset state", int'(rd_valid), 0);
        check(rd_pix1 == 8'h00, "R7 reset tap1", int'(rd_pix1), 0);
        rd_rst_n = 1;

        fork
            begin
                // R1 and R8: full-line delay, wrap without further resets
                write_phase(2 * LW + 700, 1'b0, 1, LW, "R1");
                // R9: shortened delays, periodic resets
                write_phase(16, 1'b1, 6, 16, "R9");
                write_phase(3, 1'b1, 8, 3, "R9");
                writer_done = 1;
            end
            reader();
        join

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired before completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule